// File: doc/BRIEF.md
# Two-Way Instruction Tag Tracker

This block models the tag store of a 64 KiB instruction cache with two ways per set and 64-byte lines. It holds tags only, never data. Each request gives a start address and a byte size. The block classifies the request by the line sets its first and last bytes fall into. It looks up and updates those sets, then reports whether the request hit or missed. Every miss adds one to a miss counter and raises a one-cycle strobe toward the next cache level. The strobe carries the start address and the size of the request.

Within a set, the slot called way 0 always holds the most recently touched tag. A request that spans two neighbouring sets searches both sets with the tag taken from its start address. It updates both sets and is charged at most one miss. No valid bits are kept, so after reset every slot holds tag zero, and a tag of zero counts as a real match. A request whose first and last bytes land in sets that are neither the same nor neighbours is refused: it raises a sticky error flag and leaves the store alone.

Top module: `tag_tracker_2way`

## Requirements
- R1: After reset the miss counter reads 0, the hit, miss, error and next-level outputs are low, and req_ready is high. Every slot of every set holds tag 0, so the first request whose tag is 0 hits.
- R2: The set index is address bits [14:6] and the tag is the address shifted right by 15. The last byte address is start + size − 1, computed modulo 2^32.
- R3: A request whose tag matches way 0 of its set raises hit_o and leaves the set unchanged.
- R4: A request whose tag matches way 1 raises hit_o and exchanges the two ways, so the matched tag moves to way 0 and the former way-0 tag moves to way 1.
- R5: A request that matches neither way raises miss_o. The way-0 tag moves to way 1, the old way-1 tag is dropped and the new tag goes into way 0. In the same cycle as miss_o, miss_count has already increased by one and nl_req_valid is high with nl_req_addr and nl_req_size equal to the request's start address and size.
- R6: When the last byte's set equals the start set plus one, both sets are searched and updated, each with the start address's tag. The request takes two cycles: req_ready is low, and hit_o and miss_o are low, in the cycle after acceptance. The result appears one cycle later.
- R7: A two-set request counts one miss and raises one strobe if either set misses, including when both miss. It raises hit_o only when both sets hit.
- R8: Set 511 and set 0 count as neighbours, so a request that runs from set 511 into set 0 is a two-set request.
- R9: A request whose two sets are neither equal nor neighbours sets err_o, which stays high until reset. The request raises no hit, miss or strobe, does not change the counter and changes no tag.
- R10: A request that stays inside one set keeps req_ready high. Its hit_o or miss_o pulse appears in the cycle right after acceptance, so back-to-back single-set requests give results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 32 | Start byte address |
| req_size | input | 8 | Request size in bytes |
| hit_o | output | 1 | One-cycle pulse: request hit |
| miss_o | output | 1 | One-cycle pulse: request missed |
| err_o | output | 1 | Sticky flag: request touched non-neighbouring sets |
| miss_count | output | 64 | Number of misses since reset |
| nl_req_valid | output | 1 | One-cycle request strobe to the next level |
| nl_req_addr | output | 32 | Start address carried with the strobe |
| nl_req_size | output | 8 | Size carried with the strobe |

## Verification
Two functions can coincide in one cycle. The second half of a two-set request can decide a miss in the same cycle as it folds in the miss already recorded by the first half, so a double miss could be counted twice. The bench drives requests whose first set hits and second set misses, and requests where both sets miss, including one across the 511-to-0 wrap. After each one it checks that the counter advanced by exactly one and that exactly one strobe carried the start address. A second overlap concerns the lookup tag. The second set is searched with the tag of the start address, not the end address. This is judged by a later single-set probe into set 0 that must hit on the start address's tag.

// File: rtl/tag_tracker_pkg.sv
package tag_tracker_pkg;

  // How the first and last byte of a request relate in set space
  typedef enum logic [1:0] {
    SPAN_ONE = 2'd0,
    SPAN_TWO = 2'd1,
    SPAN_BAD = 2'd2
  } span_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } tt_state_e;

endpackage

// File: rtl/tt_addr_split.sv
module tt_addr_split
  import tag_tracker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 8,
  parameter int OFF_BITS = 6,
  parameter int SET_BITS = 9,
  parameter int TAG_W    = ADDR_W - OFF_BITS - SET_BITS
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SIZE_W-1:0]   size,
  output logic [SET_BITS-1:0] set_a,
  output logic [SET_BITS-1:0] set_b,
  output logic [TAG_W-1:0]    tag,
  output span_e               span
);

  logic [ADDR_W-1:0]   last_byte;
  logic [SET_BITS-1:0] set_a_next;

  always_comb begin
    last_byte  = addr + ADDR_W'(size) - ADDR_W'(1);
    set_a      = addr[OFF_BITS +: SET_BITS];
    set_b      = last_byte[OFF_BITS +: SET_BITS];
    tag        = addr[ADDR_W-1 -: TAG_W];
    set_a_next = set_a + SET_BITS'(1);   // wraps from top set to set 0
    if (set_b == set_a)           span = SPAN_ONE;
    else if (set_b == set_a_next) span = SPAN_TWO;
    else                          span = SPAN_BAD;
  end

endmodule

// File: rtl/tt_set_store.sv
module tt_set_store #(
  parameter int SET_BITS = 9,
  parameter int TAG_W    = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  input  logic                upd_en,
  output logic                lk_hit
);

  localparam int SETS = 1 << SET_BITS;

  logic [TAG_W-1:0] mru_rd [SETS];
  logic [TAG_W-1:0] lru_rd [SETS];
  logic             hit_mru;
  logic             hit_lru;
  logic             shift_in;

  always_comb begin
    hit_mru  = (mru_rd[lk_idx] == lk_tag);
    hit_lru  = (lru_rd[lk_idx] == lk_tag);
    lk_hit   = hit_mru | hit_lru;
    // a way-1 hit and a miss both push way 0 down and insert the tag on top
    shift_in = upd_en & ~hit_mru;
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [TAG_W-1:0] mru_q;
    logic [TAG_W-1:0] lru_q;
    logic             wr_en;

    assign wr_en     = shift_in & (lk_idx == SET_BITS'(s));
    assign mru_rd[s] = mru_q;
    assign lru_rd[s] = lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mru_q <= '0;
        lru_q <= '0;
      end else if (wr_en) begin
        mru_q <= lk_tag;
        lru_q <= mru_q;
      end
    end
  end

endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tag_tracker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 8,
  parameter int SET_BITS = 9,
  parameter int TAG_W    = 17,
  parameter int CNT_W    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [SET_BITS-1:0] set_a,
  input  logic [SET_BITS-1:0] set_b,
  input  logic [TAG_W-1:0]    tag,
  input  span_e               span,
  input  logic                lk_hit,
  output logic [SET_BITS-1:0] lk_idx,
  output logic [TAG_W-1:0]    lk_tag,
  output logic                upd_en,
  output logic                hit_o,
  output logic                miss_o,
  output logic                err_o,
  output logic [CNT_W-1:0]    miss_count,
  output logic [ADDR_W-1:0]   nl_addr,
  output logic [SIZE_W-1:0]   nl_size
);

  tt_state_e           state_q, state_d;
  logic [SET_BITS-1:0] pend_set_q, pend_set_d;
  logic [TAG_W-1:0]    pend_tag_q, pend_tag_d;
  logic [ADDR_W-1:0]   pend_addr_q, pend_addr_d;
  logic [SIZE_W-1:0]   pend_size_q, pend_size_d;
  logic                pend_miss_q, pend_miss_d;
  logic                hit_q, hit_d, miss_q, miss_d, err_q, err_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [ADDR_W-1:0]   nl_addr_q, nl_addr_d;
  logic [SIZE_W-1:0]   nl_size_q, nl_size_d;
  logic                accept;
  logic                miss_any;

  assign req_ready = run & (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_comb begin
    state_d     = state_q;
    pend_set_d  = pend_set_q;
    pend_tag_d  = pend_tag_q;
    pend_addr_d = pend_addr_q;
    pend_size_d = pend_size_q;
    pend_miss_d = pend_miss_q;
    hit_d       = 1'b0;
    miss_d      = 1'b0;
    err_d       = err_q;
    nl_addr_d   = nl_addr_q;
    nl_size_d   = nl_size_q;
    lk_idx      = set_a;
    lk_tag      = tag;
    upd_en      = 1'b0;
    miss_any    = 1'b0;
    cnt_d       = cnt_q + CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          case (span)
            SPAN_ONE: begin
              upd_en    = 1'b1;
              hit_d     = lk_hit;
              miss_d    = ~lk_hit;
              nl_addr_d = req_addr;
              nl_size_d = req_size;
            end
            SPAN_TWO: begin
              upd_en      = 1'b1;
              state_d     = ST_SECOND;
              pend_set_d  = set_b;
              pend_tag_d  = tag;
              pend_addr_d = req_addr;
              pend_size_d = req_size;
              pend_miss_d = ~lk_hit;
            end
            default: err_d = 1'b1;
          endcase
        end
      end
      ST_SECOND: begin
        lk_idx    = pend_set_q;
        lk_tag    = pend_tag_q;
        upd_en    = 1'b1;
        miss_any  = pend_miss_q | ~lk_hit;
        hit_d     = ~miss_any;
        miss_d    = miss_any;
        nl_addr_d = pend_addr_q;
        nl_size_d = pend_size_q;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_set_q  <= '0;
      pend_tag_q  <= '0;
      pend_addr_q <= '0;
      pend_size_q <= '0;
      pend_miss_q <= 1'b0;
      hit_q       <= 1'b0;
      miss_q      <= 1'b0;
      err_q       <= 1'b0;
      cnt_q       <= '0;
      nl_addr_q   <= '0;
      nl_size_q   <= '0;
    end else begin
      state_q     <= state_d;
      pend_set_q  <= pend_set_d;
      pend_tag_q  <= pend_tag_d;
      pend_addr_q <= pend_addr_d;
      pend_size_q <= pend_size_d;
      pend_miss_q <= pend_miss_d;
      hit_q       <= hit_d;
      miss_q      <= miss_d;
      err_q       <= err_d;
      if (miss_d) begin
        cnt_q     <= cnt_d;
        nl_addr_q <= nl_addr_d;
        nl_size_q <= nl_size_d;
      end
    end
  end

  assign hit_o      = hit_q;
  assign miss_o     = miss_q;
  assign err_o      = err_q;
  assign miss_count = cnt_q;
  assign nl_addr    = nl_addr_q;
  assign nl_size    = nl_size_q;

endmodule

// File: rtl/tag_tracker_2way.sv
module tag_tracker_2way
  import tag_tracker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 8,
  parameter int OFF_BITS = 6,
  parameter int SET_BITS = 9,
  parameter int CNT_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              hit_o,
  output logic              miss_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  miss_count,
  output logic              nl_req_valid,
  output logic [ADDR_W-1:0] nl_req_addr,
  output logic [SIZE_W-1:0] nl_req_size
);

  localparam int TAG_W = ADDR_W - OFF_BITS - SET_BITS;

  logic [1:0]          rst_sync_q;
  logic                rst_n_int;
  logic [SET_BITS-1:0] set_a, set_b, lk_idx;
  logic [TAG_W-1:0]    tag, lk_tag;
  span_e               span;
  logic                upd_en, lk_hit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  tt_addr_split #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_BITS(OFF_BITS),
    .SET_BITS(SET_BITS), .TAG_W(TAG_W)
  ) split_i (
    .addr(req_addr), .size(req_size),
    .set_a(set_a), .set_b(set_b), .tag(tag), .span(span)
  );

  tt_set_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst_n(rst_n_int),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .upd_en(upd_en), .lk_hit(lk_hit)
  );

  tt_ctrl #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SET_BITS(SET_BITS),
    .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n_int), .run(rst_n_int),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .set_a(set_a), .set_b(set_b), .tag(tag), .span(span),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_tag(lk_tag), .upd_en(upd_en),
    .hit_o(hit_o), .miss_o(miss_o), .err_o(err_o),
    .miss_count(miss_count), .nl_addr(nl_req_addr), .nl_size(nl_req_size)
  );

  assign nl_req_valid = miss_o;

endmodule

// File: rtl/tag_tracker_2way_chk.sv
module tag_tracker_2way_chk #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 8,
  parameter int OFF_BITS = 6,
  parameter int SET_BITS = 9,
  parameter int CNT_W    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic              hit_o,
  input logic              miss_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  miss_count,
  input logic              nl_req_valid
);

  logic [ADDR_W-1:0]   c_end;
  logic [SET_BITS-1:0] c_first, c_last;
  logic                c_take, c_same, c_next;

  always_comb begin
    c_end   = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
    c_first = req_addr[OFF_BITS +: SET_BITS];
    c_last  = c_end[OFF_BITS +: SET_BITS];
    c_take  = req_valid & req_ready;
    c_same  = (c_first == c_last);
    c_next  = (c_last == c_first + SET_BITS'(1));
  end

  AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_o, miss_o})); // R3

  AST_COUNT_WITH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> (miss_count == $past(miss_count) + CNT_W'(1))); // R5

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_o |-> $stable(miss_count)); // R7

  AST_STROBE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req_valid |-> miss_o); // R5

  AST_SPLIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_take && !c_same && c_next) |=> (!req_ready && !hit_o && !miss_o)); // R6

  AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (c_take && c_same) |=> (hit_o || miss_o)); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R9

  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (c_take && !c_same && !c_next) |=> (!hit_o && !miss_o && err_o)); // R9

endmodule

bind tag_tracker_2way tag_tracker_2way_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_BITS(OFF_BITS),
  .SET_BITS(SET_BITS), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .hit_o(hit_o), .miss_o(miss_o),
  .err_o(err_o), .miss_count(miss_count), .nl_req_valid(nl_req_valid)
);

// File: tb/tag_tracker_2way_tb_top.sv
module tag_tracker_2way_tb_top;

  typedef struct packed {
    logic [31:0] a;
    logic [7:0]  sz;
    logic        h;
    logic        m;
    logic        e;
    logic [7:0]  c;
  } vec_t;

  // tag = addr>>15, set = addr[14:6]
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0040, 8'd4, 1'b1, 1'b0, 1'b0, 8'd0}, // R1 tag0 hits cleared set 1
    '{32'h0000_8040, 8'd4, 1'b0, 1'b1, 1'b0, 8'd1}, // R5 tag1 miss
    '{32'h0001_0040, 8'd4, 1'b0, 1'b1, 1'b0, 8'd2}, // R5 tag2 miss, set1 = {2,1}
    '{32'h0000_0040, 8'd4, 1'b0, 1'b1, 1'b0, 8'd3}, // R5 tag0 evicted earlier, set1 = {0,2}
    '{32'h0001_0044, 8'd2, 1'b1, 1'b0, 1'b0, 8'd3}, // R4 way-1 hit, swap -> {2,0}
    '{32'h0001_0048, 8'd1, 1'b1, 1'b0, 1'b0, 8'd3}, // R3 way-0 hit
    '{32'h0001_8040, 8'd4, 1'b0, 1'b1, 1'b0, 8'd4}, // R4 tag3 miss drops 0 -> {3,2}
    '{32'h0000_0040, 8'd4, 1'b0, 1'b1, 1'b0, 8'd5}, // R4 tag0 gone proves swap -> {0,3}
    '{32'h0001_0040, 8'd4, 1'b0, 1'b1, 1'b0, 8'd6}, // R2 tag2 miss -> {2,0}
    '{32'h0000_00BE, 8'd4, 1'b1, 1'b0, 1'b0, 8'd6}, // R6 sets 2,3 both hit tag0
    '{32'h0002_00FE, 8'd4, 1'b0, 1'b1, 1'b0, 8'd7}, // R7 sets 3,4 both miss, one count
    '{32'h0002_013E, 8'd4, 1'b0, 1'b1, 1'b0, 8'd8}, // R7 set4 hit, set5 miss
    '{32'h0002_00C0, 8'd4, 1'b1, 1'b0, 1'b0, 8'd8}, // R6 set3 now holds tag4
    '{32'h0000_7FFE, 8'd4, 1'b1, 1'b0, 1'b0, 8'd8}, // R8 set511 -> set0, tag0 hits
    '{32'h0001_FFFE, 8'd4, 1'b0, 1'b1, 1'b0, 8'd9}, // R8 wrap, both miss, one count
    '{32'h0001_8000, 8'd1, 1'b1, 1'b0, 1'b0, 8'd9}, // R6 set0 got start tag 3
    '{32'h0002_8040, 8'd0, 1'b0, 1'b0, 1'b1, 8'd9}, // R9 size 0 at line start: sets 1,0
    '{32'h0000_0040, 8'd4, 1'b1, 1'b0, 1'b1, 8'd9}, // R9 tag0 still in set1
    '{32'h0001_0040, 8'd4, 1'b1, 1'b0, 1'b1, 8'd9}  // R9 tag2 still in set1
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [7:0]  req_size;
  logic        hit_o, miss_o, err_o;
  logic [63:0] miss_count;
  logic        nl_req_valid;
  logic [31:0] nl_req_addr;
  logic [7:0]  nl_req_size;

  int n_checks = 0;
  int n_fail   = 0;

  tag_tracker_2way dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .hit_o(hit_o), .miss_o(miss_o),
    .err_o(err_o), .miss_count(miss_count), .nl_req_valid(nl_req_valid),
    .nl_req_addr(nl_req_addr), .nl_req_size(nl_req_size)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    #1;
    chk(miss_count == 0, "R1 count cleared", miss_count, 0);
    chk(!hit_o && !miss_o && !err_o && !nl_req_valid, "R1 outputs low",
        {hit_o, miss_o, err_o, nl_req_valid}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] last;
    logic        two;
    last = v.a + {24'd0, v.sz} - 32'd1;
    two  = !v.e && (last[14:6] != v.a[14:6]);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = v.a;
    req_size  = v.sz;
    @(negedge clk);
    req_valid = 1'b0;
    if (two) begin
      chk(!req_ready, "R6 ready low in second cycle", req_ready, 0);
      chk(!hit_o && !miss_o, "R6 no result in second cycle", {hit_o, miss_o}, 0);
      @(negedge clk);
    end
    chk(hit_o == v.h && miss_o == v.m, "R3/R4/R5/R7 outcome",
        {hit_o, miss_o}, {v.h, v.m});
    chk(err_o == v.e, "R9 error flag", err_o, v.e);
    chk(miss_count == 64'(v.c), "R5/R7 miss count", miss_count, 64'(v.c));
    chk(nl_req_valid == v.m, "R5 strobe", nl_req_valid, v.m);
    if (v.m) begin
      chk(nl_req_addr == v.a, "R5 strobe address", nl_req_addr, v.a);
      chk(nl_req_size == v.sz, "R5 strobe size", nl_req_size, v.sz);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_size  = '0;
    do_reset();

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9 error persists across idle cycles
    repeat (3) @(negedge clk);
    chk(err_o, "R9 sticky while idle", err_o, 1);

    // R1 mid-run reset clears count, flag and tags
    do_reset();
    chk(!err_o, "R1 error cleared", err_o, 0);

    // R10 back-to-back single-set requests, valid held high
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h0001_0040;   // tag2: store cleared, so miss
    req_size  = 8'd4;
    @(negedge clk);
    chk(req_ready, "R10 ready stays high", req_ready, 1);
    chk(miss_o && !hit_o, "R10 first result next cycle", {hit_o, miss_o}, 2'b01);
    chk(miss_count == 1, "R10 count after first", miss_count, 1);
    req_addr = 32'h0000_0080;    // tag0, set2: cleared tag 0 counts as real, R1
    @(negedge clk);
    req_valid = 1'b0;
    chk(hit_o && !miss_o, "R10 R1 second result next cycle", {hit_o, miss_o}, 2'b10);
    chk(miss_count == 1, "R10 count unchanged on hit", miss_count, 1);
    @(negedge clk);
    chk(!hit_o && !miss_o, "R10 pulses end", {hit_o, miss_o}, 0);

    report();
  end

endmodule